// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for an LCD panel. It makes a one-cycle pixel enable, a pixel clock level, horizontal and vertical sync, a data-enable window, an AC-bias drive for passive panels, and the raw horizontal and vertical position counters. A fetch or pixel pipeline clocked by the same logic clock uses the pixel enable, the data-enable window and the counters to know when to present each pixel.

All geometry comes from three 32-bit configuration words that the block only slices into fields. Horizontal widths are held as value minus one. Vertical sync width and active height are also held as value minus one, but the vertical porches are held as plain counts, so a zero porch is allowed. A panel-type input selects TFT or passive operation. This input sets the smallest pixel divider that is allowed and decides whether the AC-bias output toggles. Each line, and likewise each frame, runs in the order sync, back porch, active, front porch.

Top module: `lcd_raster_gen`

## Requirements
- R1: While rst_n is low, h_cnt and v_cnt read 0 and pix_en reads 0.
- R2: Word tcfg0 holds active pixels minus 1 in [9:0], hsync width minus 1 in [15:10], front porch minus 1 in [23:16] and back porch minus 1 in [31:24]. h_cnt counts pixel enables and wraps to 0 after reaching the sum of the four decoded widths minus 1.
- R3: Word tcfg1 holds active lines minus 1 in [9:0] and vsync width minus 1 in [15:10]. It holds the front porch in [23:16] and the back porch in [31:24], both taken as-is and allowed to be 0. v_cnt wraps the same way over the vertical total.
- R4: pix_en pulses for one cycle every D clocks, starting D-1 cycles after reset. D is the value in tcfg2[7:0], raised to 2 when tft_mode=1 and to 3 when tft_mode=0.
- R5: Before inversion, the pixel clock level is high for the first floor(D/2) cycles of each D-cycle period.
- R6: The unpolarised hsync is active while h_cnt is below the hsync width. Data enable is active while h_cnt is in [sync+back porch, sync+back porch+active) and v_cnt is in the vertical equivalent.
- R7: v_cnt advances only on the pixel enable that wraps h_cnt. The unpolarised vsync is active while v_cnt is below the vsync width.
- R8: With tft_mode=0, the AC-bias level toggles after every N+1 completed lines, where N is tcfg2[15:8]. With tft_mode=1 it holds low.
- R9: Each polarity bit, when set, inverts one output: tcfg2[20] inverts hsync, [21] vsync, [22] the pixel clock level, [23] data enable and [24] AC-bias. tcfg2[25] is reserved and has no effect.
- R10: If a new configuration leaves a counter beyond its new total, the counter returns to 0 on its next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tft_mode | input | 1 | 1 = TFT panel, 0 = passive panel |
| tcfg0 | input | 32 | Horizontal geometry word |
| tcfg1 | input | 32 | Vertical geometry word |
| tcfg2 | input | 32 | Divider, AC-bias count, polarity bits |
| pix_en | output | 1 | One-cycle pixel enable |
| pclk_o | output | 1 | Pixel clock level after polarity |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| acb_o | output | 1 | AC-bias drive after polarity |
| h_cnt | output | 12 | Position within the line |
| v_cnt | output | 12 | Line within the frame |

## Verification
The hardest case to reach from the ports is a position counter that sits beyond its total. This only happens when the geometry shrinks while the raster is running. The bench starts a long line, waits until h_cnt is past where the shorter line would end, rewrites tcfg0 without a reset, and checks that the next pixel enable returns h_cnt to 0 and moves v_cnt on by one. The rest of the stimulus is a sweep over several small geometries, using zero vertical porches, the clamped divider values and all polarity settings. Every output is compared on every cycle against values derived arithmetically from the number of clocks since reset.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int POS_W = 12;
    localparam int DIV_W = 8;
    localparam int ACB_W = 8;
    localparam int POL_N = 5;

    typedef struct packed {
        logic [POS_W-1:0] h_act;
        logic [POS_W-1:0] h_sync;
        logic [POS_W-1:0] h_bp;
        logic [POS_W-1:0] h_fp;
        logic [POS_W-1:0] v_act;
        logic [POS_W-1:0] v_sync;
        logic [POS_W-1:0] v_bp;
        logic [POS_W-1:0] v_fp;
        logic [DIV_W-1:0] div;
        logic [ACB_W-1:0] acb_n;
        logic [POL_N-1:0] pol;   // 0 hs, 1 vs, 2 pclk, 3 de, 4 acb
    } timing_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } axis_st_t;

    typedef struct packed {
        logic [ACB_W-1:0] cnt;
        logic             lvl;
    } acb_st_t;

    function automatic timing_t decode_timing(input logic [31:0] w0,
                                              input logic [31:0] w1,
                                              input logic [31:0] w2);
        timing_t t;
        t.h_act  = POS_W'(w0[9:0])   + POS_W'(1);
        t.h_sync = POS_W'(w0[15:10]) + POS_W'(1);
        t.h_fp   = POS_W'(w0[23:16]) + POS_W'(1);
        t.h_bp   = POS_W'(w0[31:24]) + POS_W'(1);
        t.v_act  = POS_W'(w1[9:0])   + POS_W'(1);
        t.v_sync = POS_W'(w1[15:10]) + POS_W'(1);
        t.v_fp   = POS_W'(w1[23:16]);
        t.v_bp   = POS_W'(w1[31:24]);
        t.div    = w2[7:0];
        t.acb_n  = w2[15:8];
        t.pol    = w2[24:20];
        return t;
    endfunction

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tft,
    input  logic [DIV_W-1:0] div_val,
    output logic             pix_en,
    output logic             pclk_raw
);
    localparam logic [DIV_W-1:0] MIN_TFT = DIV_W'(2);
    localparam logic [DIV_W-1:0] MIN_PAS = DIV_W'(3);

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] floor_v, eff, last;

    always_comb begin
        floor_v = tft ? MIN_TFT : MIN_PAS;
        eff     = (div_val < floor_v) ? floor_v : div_val;
        last    = eff - DIV_W'(1);
        // >= lets a shrunk divider recover at once
        pix_en   = (st_q.cnt >= last);
        pclk_raw = (st_q.cnt < (eff >> 1));
        st_d     = st_q;
        st_d.cnt = pix_en ? '0 : st_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_axis.sv
module lcd_axis
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [POS_W-1:0] sync_len,
    input  logic [POS_W-1:0] bp_len,
    input  logic [POS_W-1:0] act_len,
    input  logic [POS_W-1:0] fp_len,
    output logic [POS_W-1:0] pos,
    output logic             in_sync,
    output logic             in_act,
    output logic             at_end
);
    axis_st_t st_d, st_q;
    logic [POS_W-1:0] act_lo, act_hi, total;

    always_comb begin
        act_lo  = sync_len + bp_len;
        act_hi  = act_lo + act_len;
        total   = act_hi + fp_len;
        pos     = st_q.pos;
        in_sync = (st_q.pos < sync_len);
        in_act  = (st_q.pos >= act_lo) && (st_q.pos < act_hi);
        at_end  = (st_q.pos >= total - POS_W'(1));
        st_d    = st_q;
        if (step) begin
            st_d.pos = at_end ? '0 : st_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_acb.sv
module lcd_acb
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tft,
    input  logic             line_step,
    input  logic [ACB_W-1:0] span,
    output logic             lvl
);
    acb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tft) begin
            st_d = '0;
        end else if (line_step) begin
            if (st_q.cnt >= span) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + ACB_W'(1);
            end
        end
        lvl = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tft_mode,
    input  logic [31:0]      tcfg0,
    input  logic [31:0]      tcfg1,
    input  logic [31:0]      tcfg2,
    output logic             pix_en,
    output logic             pclk_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             acb_o,
    output logic [POS_W-1:0] h_cnt,
    output logic [POS_W-1:0] v_cnt
);
    timing_t tm;
    logic pclk_raw, hs_raw, vs_raw, h_de, v_de, de_raw;
    logic h_wrap, line_step, acb_lvl, unused_v_end;
    logic unused_cfg_bits;

    assign tm = decode_timing(tcfg0, tcfg1, tcfg2);
    assign unused_cfg_bits = ^{tcfg2[31:25], tcfg2[19:16]};

    lcd_pix_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tft      (tft_mode),
        .div_val  (tm.div),
        .pix_en   (pix_en),
        .pclk_raw (pclk_raw)
    );

    lcd_axis u_haxis (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (pix_en),
        .sync_len (tm.h_sync),
        .bp_len   (tm.h_bp),
        .act_len  (tm.h_act),
        .fp_len   (tm.h_fp),
        .pos      (h_cnt),
        .in_sync  (hs_raw),
        .in_act   (h_de),
        .at_end   (h_wrap)
    );

    assign line_step = pix_en & h_wrap;

    lcd_axis u_vaxis (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (line_step),
        .sync_len (tm.v_sync),
        .bp_len   (tm.v_bp),
        .act_len  (tm.v_act),
        .fp_len   (tm.v_fp),
        .pos      (v_cnt),
        .in_sync  (vs_raw),
        .in_act   (v_de),
        .at_end   (unused_v_end)
    );

    lcd_acb u_acb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tft       (tft_mode),
        .line_step (line_step),
        .span      (tm.acb_n),
        .lvl       (acb_lvl)
    );

    assign de_raw  = h_de & v_de;
    assign hsync_o = hs_raw   ^ tm.pol[0];
    assign vsync_o = vs_raw   ^ tm.pol[1];
    assign pclk_o  = pclk_raw ^ tm.pol[2];
    assign de_o    = de_raw   ^ tm.pol[3];
    assign acb_o   = acb_lvl  ^ tm.pol[4];
endmodule

// File: rtl/lcd_raster_gen_chk.sv
module lcd_raster_gen_chk
    import lcd_tg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tft_mode,
    input logic             pix_en,
    input logic             h_wrap,
    input logic             acb_lvl,
    input logic             de_raw,
    input logic             hs_raw,
    input logic             vs_raw,
    input logic [POS_W-1:0] h_cnt,
    input logic [POS_W-1:0] v_cnt
);
    // R4
    pix_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en);

    // R2
    h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(h_cnt));

    // R7
    v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && h_wrap) |=> $stable(v_cnt));

    // R6
    de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (!hs_raw && !vs_raw));

    // R8
    acb_tft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tft_mode && $past(tft_mode)) |-> !acb_lvl);
endmodule

bind lcd_raster_gen lcd_raster_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tft_mode (tft_mode),
    .pix_en   (pix_en),
    .h_wrap   (h_wrap),
    .acb_lvl  (acb_lvl),
    .de_raw   (de_raw),
    .hs_raw   (hs_raw),
    .vs_raw   (vs_raw),
    .h_cnt    (h_cnt),
    .v_cnt    (v_cnt)
);

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tft_mode = 1'b1;
    logic [31:0] tcfg0 = '0, tcfg1 = '0, tcfg2 = '0;
    logic        pix_en, pclk_o, hsync_o, vsync_o, de_o, acb_o;
    logic [11:0] h_cnt, v_cnt;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    lcd_raster_gen u_lcd_raster_gen (
        .clk(clk), .rst_n(rst_n), .tft_mode(tft_mode),
        .tcfg0(tcfg0), .tcfg1(tcfg1), .tcfg2(tcfg2),
        .pix_en(pix_en), .pclk_o(pclk_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .acb_o(acb_o),
        .h_cnt(h_cnt), .v_cnt(v_cnt)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk0(int hs, int hb, int ha, int hf);
        return {8'(hb-1), 8'(hf-1), 6'(hs-1), 10'(ha-1)};
    endfunction

    function automatic logic [31:0] mk1(int vs, int vb, int va, int vf);
        return {8'(vb), 8'(vf), 6'(vs-1), 10'(va-1)};
    endfunction

    task automatic run_case(input bit tft, input int hs, input int hb, input int ha, input int hf,
                            input int vs, input int vb, input int va, input int vf,
                            input int dv, input int an, input logic [5:0] pol, input int frames);
        int eff, ht, vt, cycles;
        @(negedge clk);
        rst_n    = 1'b0;
        tft_mode = tft;
        tcfg0    = mk0(hs, hb, ha, hf);
        tcfg1    = mk1(vs, vb, va, vf);
        tcfg2    = {6'd0, pol, 4'd0, 8'(an), 8'(dv)};
        @(negedge clk);
        // R1 reset state
        chk("R1", "h_cnt in reset", int'(h_cnt), 0);
        chk("R1", "v_cnt in reset", int'(v_cnt), 0);
        chk("R1", "pix_en in reset", int'(pix_en), 0);
        rst_n = 1'b1;
        eff = tft ? ((dv < 2) ? 2 : dv) : ((dv < 3) ? 3 : dv);
        ht = hs + hb + ha + hf;
        vt = vs + vb + va + vf;
        cycles = frames * eff * ht * vt;
        for (int n = 0; n < cycles; n++) begin
            int p, h, ln, v, ph;
            bit e_hs, e_vs, e_de, e_acb, e_pclk;
            p  = n / eff;
            ph = n % eff;
            h  = p % ht;
            ln = p / ht;
            v  = ln % vt;
            e_hs   = (h < hs);
            e_vs   = (v < vs);
            e_de   = (h >= hs + hb) && (h < hs + hb + ha) && (v >= vs + vb) && (v < vs + vb + va);
            e_acb  = tft ? 1'b0 : 1'(((ln / (an + 1)) % 2));
            e_pclk = (ph < eff / 2);
            chk("R2", "h_cnt", int'(h_cnt), h);
            chk("R3", "v_cnt", int'(v_cnt), v);
            chk("R4", "pix_en", int'(pix_en), int'(ph == eff - 1));
            chk("R5/R9", "pclk_o", int'(pclk_o), int'(e_pclk ^ pol[2]));
            chk("R6/R9", "hsync_o", int'(hsync_o), int'(e_hs ^ pol[0]));
            chk("R7/R9", "vsync_o", int'(vsync_o), int'(e_vs ^ pol[1]));
            chk("R6/R9", "de_o", int'(de_o), int'(e_de ^ pol[3]));
            chk("R8/R9", "acb_o", int'(acb_o), int'(e_acb ^ pol[4]));
            @(negedge clk);
        end
    endtask

    task automatic shrink_case();
        int guard;
        @(negedge clk);
        rst_n    = 1'b0;
        tft_mode = 1'b1;
        tcfg0    = mk0(2, 1, 20, 1);
        tcfg1    = mk1(1, 0, 3, 2);
        tcfg2    = 32'd2;
        @(negedge clk);
        rst_n = 1'b1;
        guard = 0;
        while (h_cnt != 12'd15 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        // R10 shorten the line while h_cnt sits past its new end
        tcfg0 = mk0(2, 1, 4, 1);
        guard = 0;
        while (!pix_en && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk("R10", "h_cnt after shrink", int'(h_cnt), 0);
        chk("R10", "v_cnt after shrink", int'(v_cnt), 1);
    endtask

    initial begin
        // watchdog
        wait (cyc > 190000);
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // TFT, divider 0 clamps to 2, zero vertical back porch
        run_case(1'b1, 2, 1, 4, 1,  1, 0, 3, 2,  0, 0, 6'b000000, 2);
        // passive, divider 1 clamps to 3, all polarities set, reserved bit set
        run_case(1'b0, 2, 1, 4, 1,  1, 1, 3, 0,  1, 2, 6'b111111, 3);
        // TFT, divider 5, AC-bias count ignored
        run_case(1'b1, 1, 2, 3, 2,  2, 1, 2, 1,  5, 5, 6'b000001, 2);
        // passive, divider 4, vsync and data-enable inverted
        run_case(1'b0, 3, 2, 2, 1,  1, 2, 2, 1,  4, 1, 6'b001010, 3);
        // passive, divider 2 clamps to 3, AC-bias toggles each line
        run_case(1'b0, 1, 1, 1, 1,  1, 0, 1, 0,  2, 0, 6'b010100, 4);
        // maximum divider
        run_case(1'b1, 2, 1, 4, 1,  1, 0, 3, 2,  255, 0, 6'b000100, 1);
        shrink_case();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule